// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate Controller

This block sits between a clock generator's dividers and its output pins. It takes a vector of already divided clock waveforms, all generated from the CPU-domain reference clock, and decides cycle by cycle which of them reach their outputs. Four things can silence an output: an active-low power-down request that arrives asynchronously, an active-low CPU-stop request, an active-low PCI-stop request, and a per-output enable bit from a configuration register.

Every request passes through a two-flop synchronizer. Power-down counts only after it has been seen low on two consecutive reference edges. Each output has its own gate flop, and that flop may change only while its raw clock is low. As a result, a clock is always stopped after a complete high phase and always restarts with a complete high phase. A registered PLL-enable indication falls once power-down is qualified.

Which outputs each stop request affects, and which output ignores its enable bit, are set by parameter masks. The defaults give a free-running CPU clock, a stoppable CPU clock, a free-running PCI clock, two stoppable PCI clocks and a memory-hub clock that is always enabled.

Top module: `clkgate_ctrl`

## Requirements
- R1: While reset is asserted, every gated output is LOW and the PLL-enable output is HIGH.
- R2: The power-down request is synchronized and must be sampled LOW on two consecutive reference edges. A request that is LOW for only one edge leaves the PLL-enable output HIGH. A request held LOW from just before edge k drops the PLL-enable output after edge k+3.
- R3: Once power-down is qualified, all outputs are held LOW, including the free-running ones and output bit 6. The PLL-enable output is LOW. When the request is removed, the PLL-enable output returns HIGH and the outputs run again.
- R4: CPU-stop LOW holds output bit 1 LOW. Output bit 0, the free-running CPU clock, keeps toggling.
- R5: PCI-stop LOW holds output bits 3 and 4 LOW. Output bit 2, the free-running PCI clock, keeps toggling.
- R6: An enable bit of 0 holds the matching output LOW. Output bit 6, the memory-hub clock, runs whatever its enable bit is.
- R7: The gate of an output changes only while its raw clock is LOW. A high phase already started is never cut short, and an output never goes high part-way through a high phase of its raw clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | CPU-stop request, active low |
| pci_stop_n | input | 1 | PCI-stop request, active low |
| cfg_en | input | NCLK | Per-output enable bits from the configuration register |
| raw_clk | input | NCLK | Divided clocks to be gated |
| gclk | output | NCLK | Gated clock outputs |
| pll_en | output | 1 | PLL-enable indication, LOW in power-down |

## Verification
The bench builds the block with its default parameters: eight outputs, CPU-stop on bit 1, PCI-stop on bits 3 and 4, and bit 6 free of its enable. Bits 0 to 3 are driven with a divide-by-two waveform and bits 4 to 7 with a divide-by-four waveform. The divide-by-four clocks stay high across a whole reference cycle, so a request can land in the middle of a high phase, and that is the case that exposes a truncated or late-starting pulse. The bench measures the exact edge at which power-down is qualified and also sends a one-edge power-down glitch that must be rejected.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  // Synchronized request bundle, all active low
  typedef struct packed {
    logic pwrdn_n;
    logic cpu_stop_n;
    logic pci_stop_n;
  } req_t;

  localparam int unsigned REQ_W = $bits(req_t);
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[gs] <= '1;
        else        stg_q[gs] <= stg_d[gs];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pd_qualify.sv
module pd_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_sync_n,
  output logic pd_active
);
  logic low_seen_q, low_seen_d;
  logic active_q, active_d;

  always_comb begin
    low_seen_d = !pd_sync_n;
    active_d   = !pd_sync_n && low_seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_seen_q <= 1'b0;
      active_q   <= 1'b0;
    end else begin
      low_seen_q <= low_seen_d;
      active_q   <= active_d;
    end
  end

  assign pd_active = active_q;
endmodule

// File: rtl/gate_cell.sv
module gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic want,
  output logic gout
);
  logic en_q, en_d;
  logic upd;

  assign upd = !raw;

  always_comb begin
    en_d = en_q;
    if (upd) en_d = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign gout = raw & en_q;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int unsigned     NCLK          = 8,
  parameter logic [NCLK-1:0] CPU_STOP_MASK = 8'b0000_0010,
  parameter logic [NCLK-1:0] PCI_STOP_MASK = 8'b0001_1000,
  parameter logic [NCLK-1:0] NO_EN_MASK    = 8'b0100_0000,
  parameter int unsigned     SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwrdn_n,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic [NCLK-1:0] cfg_en,
  input  logic [NCLK-1:0] raw_clk,
  output logic [NCLK-1:0] gclk,
  output logic            pll_en
);
  req_t req_raw, req_s;
  logic pd_active;
  logic cpu_stop, pci_stop;
  logic [NCLK-1:0] want;

  assign req_raw = '{pwrdn_n: pwrdn_n, cpu_stop_n: cpu_stop_n, pci_stop_n: pci_stop_n};

  req_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
  );

  pd_qualify u_pdq (
    .clk(clk), .rst_n(rst_n), .pd_sync_n(req_s.pwrdn_n), .pd_active(pd_active)
  );

  assign cpu_stop = !req_s.cpu_stop_n;
  assign pci_stop = !req_s.pci_stop_n;
  assign pll_en   = !pd_active;

  genvar gi;
  generate
    for (gi = 0; gi < NCLK; gi++) begin : g_out
      always_comb begin
        want[gi] = !pd_active
                 && (cfg_en[gi] || NO_EN_MASK[gi])
                 && !(cpu_stop && CPU_STOP_MASK[gi])
                 && !(pci_stop && PCI_STOP_MASK[gi]);
      end

      gate_cell u_gate (
        .clk(clk), .rst_n(rst_n), .raw(raw_clk[gi]),
        .want(want[gi]), .gout(gclk[gi])
      );
    end
  endgenerate
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int unsigned NCLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwrdn_n,
  input logic [NCLK-1:0] raw_clk,
  input logic [NCLK-1:0] gclk,
  input logic            pll_en
);
  // R2: PLL-enable falls only after two consecutive low samples of the request
  a_r2_pd_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (!$past(pwrdn_n, 3) && !$past(pwrdn_n, 4)));

  genvar gi;
  generate
    for (gi = 0; gi < NCLK; gi++) begin : g_chk
      // R7: an output never goes high unless its raw clock goes high with it
      a_r7_rise_with_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gclk[gi]) |-> $rose(raw_clk[gi]));
      // R7: an output never goes low unless its raw clock goes low with it
      a_r7_fall_with_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gclk[gi]) |-> $fell(raw_clk[gi]));
      // R3: no new high phase begins once power-down was in force before it
      a_r3_no_start_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gclk[gi]) |-> $past(pll_en));
    end
  endgenerate
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.NCLK(NCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
  .raw_clk(raw_clk), .gclk(gclk), .pll_en(pll_en)
);

// File: tb/clkgate_ctrl_bench.sv
module clkgate_ctrl_bench;
  localparam int NCLK = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic pwrdn_n, cpu_stop_n, pci_stop_n;
  logic [NCLK-1:0] cfg_en;
  logic [NCLK-1:0] raw_clk;
  logic [NCLK-1:0] gclk;
  logic pll_en;
  logic [1:0] div_cnt = 2'b00;

  int checks = 0;
  int errors = 0;
  int pending = 0;

  typedef struct {
    logic [NCLK-1:0] run_mask;
    string           tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    div_cnt = div_cnt + 2'd1;
  end
  assign raw_clk = {{4{div_cnt[1]}}, {4{div_cnt[0]}}};

  clkgate_ctrl u_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .cfg_en(cfg_en), .raw_clk(raw_clk),
    .gclk(gclk), .pll_en(pll_en)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // driver: push expectation, wait until the monitor has consumed it
  task automatic expect_run(input logic [NCLK-1:0] mask, input string tag);
    exp_t it;
    it.run_mask = mask;
    it.tag      = tag;
    pending++;
    sb_q.push_back(it);
    wait (pending == 0);
  endtask

  // monitor: compare outputs against raw clocks masked by expectation
  initial forever begin
    exp_t it;
    bit ok;
    logic [NCLK-1:0] bad_act, bad_exp;
    wait (sb_q.size() > 0);
    it = sb_q.pop_front();
    ok = 1'b1;
    bad_act = '0;
    bad_exp = '0;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1;
      if (gclk !== (raw_clk & it.run_mask)) begin
        ok = 1'b0;
        bad_act = gclk;
        bad_exp = raw_clk & it.run_mask;
      end
    end
    check(ok, it.tag, {8'h0, bad_act}, {8'h0, bad_exp});
    pending--;
  end

  // R7 window check on bit idx: no truncated high phase, no late start
  task automatic watch_whole(input int idx, input int n, input string tag);
    bit ok = 1'b1;
    logic pg, pr;
    @(posedge clk); #1;
    pg = gclk[idx];
    pr = raw_clk[idx];
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      if (pr && raw_clk[idx] && (gclk[idx] !== pg)) ok = 1'b0;
      pg = gclk[idx];
      pr = raw_clk[idx];
    end
    check(ok, tag, {15'h0, gclk[idx]}, {15'h0, pg});
  endtask

  initial begin
    #20000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pwrdn_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    cfg_en = '1;
    wait_cyc(3); #1;
    check(gclk === '0, "R1 outputs low in reset", {8'h0, gclk}, 16'h0);
    check(pll_en === 1'b1, "R1 pll_en high in reset", {15'h0, pll_en}, 16'h1);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(12);
    expect_run(8'hFF, "R6 all enabled outputs run");

    // R4 cpu stop
    @(negedge clk); cpu_stop_n = 1'b0;
    wait_cyc(12);
    expect_run(8'hFD, "R4 cpu stop gates bit1 only");
    @(negedge clk); cpu_stop_n = 1'b1;
    wait_cyc(12);
    expect_run(8'hFF, "R4 cpu stop released");

    // R5 pci stop, with R7 watch on div4 bit4
    @(negedge clk); pci_stop_n = 1'b0;
    watch_whole(4, 12, "R7 whole pulses on stop");
    expect_run(8'hE7, "R5 pci stop gates bits3,4");
    @(negedge clk); pci_stop_n = 1'b1;
    watch_whole(4, 12, "R7 whole pulses on resume");
    expect_run(8'hFF, "R5 pci stop released");

    // R6 enables
    @(negedge clk); cfg_en = 8'h00;
    wait_cyc(12);
    expect_run(8'h40, "R6 only bit6 ignores enables");
    @(negedge clk); cfg_en = 8'hF7;
    wait_cyc(12);
    expect_run(8'hF7, "R6 bit3 disabled");
    @(negedge clk); cfg_en = 8'hFF;
    wait_cyc(12);

    // R2 one-edge glitch rejected
    @(negedge clk); pwrdn_n = 1'b0;
    @(negedge clk); pwrdn_n = 1'b1;
    wait_cyc(8); #1;
    check(pll_en === 1'b1, "R2 single-edge power-down ignored", {15'h0, pll_en}, 16'h1);
    expect_run(8'hFF, "R2 outputs unaffected by glitch");

    // R2 exact qualification latency
    @(negedge clk); pwrdn_n = 1'b0;
    wait_cyc(3); #1;
    check(pll_en === 1'b1, "R2 pll_en still high after edge k+2", {15'h0, pll_en}, 16'h1);
    @(posedge clk); #1;
    check(pll_en === 1'b0, "R2 pll_en low after edge k+3", {15'h0, pll_en}, 16'h0);
    wait_cyc(12);
    expect_run(8'h00, "R3 all outputs low in power-down");
    @(negedge clk); pwrdn_n = 1'b1;
    wait_cyc(12); #1;
    check(pll_en === 1'b1, "R3 pll_en restored", {15'h0, pll_en}, 16'h1);
    expect_run(8'hFF, "R3 outputs resume after power-down");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule